// File: doc/BRIEF.md
# Gray-Coded Event Timer with Match Interrupt

This block is a free-running 42-bit event timer whose count is held and presented in Gray code. Software reads the count through two word registers. The low word carries the lower 32 bits. The high word carries the top 10 bits, right-aligned. Reading software turns the Gray value back into binary with a cascade of XOR-shifts. Because only one bit changes between neighbouring counts, a reader in another clock domain never sees a wildly wrong value.

A 42-bit compare value, also in Gray code, is written in two halves: the low half first, then the high half. Writing the high half starts a transfer of the combined value into the comparator. The transfer is modelled as a fixed synchronisation delay, and a busy bit stays up for that delay. While busy is up, writes to either compare half are dropped. When the count equals the active compare value, a sticky event flag is set. The flag stays set until software writes a one to it. The interrupt line is the flag gated by an enable bit.

Register word addresses: 0 count low, 1 count high, 2 compare low, 3 compare high, 4 control. The control word holds the event flag in bit 0 (write one to clear), the interrupt enable in bit 1 (read/write) and the busy bit in bit 2 (read only). Writes to the count words have no effect.

Top module: `gray_event_timer`

## Requirements
- R1: While reset is active, the count words read 0, compare low reads 0xFFFFFFFF, compare high reads 0x3FF, control reads 0 and irq_o is 0.
- R2: The count advances by one every clock. Word 0 returns the Gray code (b ^ (b >> 1)) of the binary count, so two successive samples differ in exactly one bit.
- R3: Word 1 returns count bits 41:32 in its bits 9:0, and its bits 31:10 read 0.
- R4: Compare low (word 2) reads back the last accepted 32-bit write. Compare high (word 3) reads back bits 9:0 of the last accepted write, with bits 31:10 reading 0.
- R5: An accepted write to compare high raises busy (control bit 2) for exactly 3 clocks. Busy falls on the edge where the new 42-bit compare value becomes active.
- R6: Writes to compare low or compare high while busy is 1 are ignored, and they do not extend the busy period.
- R7: The event flag (control bit 0) becomes 1 one clock after the cycle in which the 42-bit Gray count equals the active compare value. A compare value that matches only in the low 32 bits never sets it.
- R8: The event flag stays set whatever the enable bit is. Writing 1 to control bit 0 clears it, and writing 0 there leaves it unchanged.
- R9: irq_o is 1 exactly when the event flag and the enable bit (control bit 1) are both 1.
- R10: A write of 1 to control bit 0 in the same cycle as a new match leaves the flag set.
- R11: One control write can clear the flag and change the enable bit together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 3 | Word address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, a combinational function of reg_addr and state |
| irq_o | output | 1 | Interrupt: event flag AND enable |

## Verification
Reads are combinational, so a register value is visible in the same cycle it is addressed. The bench samples everything at the falling edge, halfway between updates. After a compare-high write edge, busy reads 1 at the next three falling edges and 0 at the fourth; the new compare value is active from that fourth sample onward. The bench converts each sampled Gray count to binary. At the falling edge where that binary value equals the target, it expects the flag and irq_o to still be low. At the next falling edge it expects them high. For the same-cycle clear case, the write is driven at that first falling edge so that it meets the match on the same rising edge.

// File: rtl/gtmr_pkg.sv
`timescale 1ns/1ps
package gtmr_pkg;
  // Word addresses of the register file
  typedef enum logic [2:0] {
    IDX_CNT_LO = 3'd0,
    IDX_CNT_HI = 3'd1,
    IDX_CMP_LO = 3'd2,
    IDX_CMP_HI = 3'd3,
    IDX_CTRL   = 3'd4
  } reg_idx_e;

  // Control word bit positions
  localparam int CTL_FLAG = 0;
  localparam int CTL_EN   = 1;
  localparam int CTL_BUSY = 2;
endpackage

// File: rtl/gtmr_counter.sv
`timescale 1ns/1ps
module gtmr_counter #(
  parameter int CNT_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_gray
);
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nxt;

  function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign bin_nxt = bin_q + CNT_W'(1);

  // Binary count drives the increment; the Gray mirror is registered
  // from the same next value, so both stay aligned cycle for cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_q    <= '0;
      cnt_gray <= '0;
    end else begin
      bin_q    <= bin_nxt;
      cnt_gray <= bin2gray(bin_nxt);
    end
  end
endmodule

// File: rtl/gtmr_match.sv
`timescale 1ns/1ps
module gtmr_match #(
  parameter int REG_W       = 32,
  parameter int HI_W        = 10,
  parameter int SYNC_CYCLES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      stage_lo,
  output logic [HI_W-1:0]       stage_hi,
  output logic [REG_W+HI_W-1:0] match_gray,
  output logic                  busy
);
  localparam int BW = $clog2(SYNC_CYCLES + 1);

  logic [BW-1:0] busy_cnt;
  logic          accept_lo;
  logic          accept_hi;
  logic          xfer_now;

  assign busy      = (busy_cnt != '0);
  assign accept_lo = wr_lo && !busy;
  assign accept_hi = wr_hi && !busy;
  assign xfer_now  = (busy_cnt == BW'(1));

  // Staging halves: written by software, all ones out of reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_lo <= '1;
      stage_hi <= '1;
    end else begin
      if (accept_lo) stage_lo <= wdata;
      if (accept_hi) stage_hi <= wdata[HI_W-1:0];
    end
  end

  // Synchroniser model: fixed countdown, then load the comparator copy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt   <= '0;
      match_gray <= '1;
    end else begin
      if (accept_hi) begin
        busy_cnt <= BW'(SYNC_CYCLES);
      end else if (busy) begin
        busy_cnt <= busy_cnt - BW'(1);
      end
      if (xfer_now) match_gray <= {stage_hi, stage_lo};
    end
  end
endmodule

// File: rtl/gtmr_event.sv
`timescale 1ns/1ps
module gtmr_event #(
  parameter int CNT_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_gray,
  input  logic [CNT_W-1:0] match_gray,
  input  logic             flag_w1c,
  input  logic             en_wr,
  input  logic             en_val,
  output logic             hit,
  output logic             flag_q,
  output logic             en_q,
  output logic             irq
);
  // Gray equality is plain bit equality; no conversion needed
  assign hit = (cnt_gray == match_gray);
  assign irq = flag_q & en_q;

  // A match has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (hit)           flag_q <= 1'b1;
      else if (flag_w1c) flag_q <= 1'b0;
      if (en_wr)         en_q   <= en_val;
    end
  end
endmodule

// File: rtl/gray_event_timer.sv
`timescale 1ns/1ps
module gray_event_timer
  import gtmr_pkg::*;
#(
  parameter int CNT_W       = 42,
  parameter int REG_W       = 32,
  parameter int SYNC_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_o
);
  localparam int HI_W = CNT_W - REG_W;
  localparam int PAD  = REG_W - HI_W;

  logic [CNT_W-1:0] cnt_gray;
  logic [CNT_W-1:0] match_gray;
  logic [REG_W-1:0] stage_lo;
  logic [HI_W-1:0]  stage_hi;
  logic             busy;
  logic             match_hit;
  logic             flag_q;
  logic             en_q;
  logic             wr_cmp_lo;
  logic             wr_cmp_hi;
  logic             wr_ctrl;

  assign wr_cmp_lo = reg_wr && (reg_addr == IDX_CMP_LO);
  assign wr_cmp_hi = reg_wr && (reg_addr == IDX_CMP_HI);
  assign wr_ctrl   = reg_wr && (reg_addr == IDX_CTRL);

  gtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_gray (cnt_gray)
  );

  gtmr_match #(.REG_W(REG_W), .HI_W(HI_W), .SYNC_CYCLES(SYNC_CYCLES)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo      (wr_cmp_lo),
    .wr_hi      (wr_cmp_hi),
    .wdata      (reg_wdata),
    .stage_lo   (stage_lo),
    .stage_hi   (stage_hi),
    .match_gray (match_gray),
    .busy       (busy)
  );

  gtmr_event #(.CNT_W(CNT_W)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_gray   (cnt_gray),
    .match_gray (match_gray),
    .flag_w1c   (wr_ctrl && reg_wdata[CTL_FLAG]),
    .en_wr      (wr_ctrl),
    .en_val     (reg_wdata[CTL_EN]),
    .hit        (match_hit),
    .flag_q     (flag_q),
    .en_q       (en_q),
    .irq        (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IDX_CNT_LO: reg_rdata = cnt_gray[REG_W-1:0];
      IDX_CNT_HI: reg_rdata = {{PAD{1'b0}}, cnt_gray[CNT_W-1:REG_W]};
      IDX_CMP_LO: reg_rdata = stage_lo;
      IDX_CMP_HI: reg_rdata = {{PAD{1'b0}}, stage_hi};
      IDX_CTRL: begin
        reg_rdata[CTL_FLAG] = flag_q;
        reg_rdata[CTL_EN]   = en_q;
        reg_rdata[CTL_BUSY] = busy;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gtmr_checker.sv
`timescale 1ns/1ps
module gtmr_checker
  import gtmr_pkg::*;
#(
  parameter int CNT_W       = 42,
  parameter int REG_W       = 32,
  parameter int SYNC_CYCLES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_gray,
  input logic             match_hit,
  input logic             flag_q,
  input logic             en_q,
  input logic             busy,
  input logic [REG_W-1:0] stage_lo
);
  logic [15:0] busy_run;
  logic        ctl_clear;
  logic        cmp_wr;

  assign ctl_clear = reg_wr && (reg_addr == IDX_CTRL) && reg_wdata[CTL_FLAG];
  assign cmp_wr    = reg_wr && ((reg_addr == IDX_CMP_LO) || (reg_addr == IDX_CMP_HI));

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 16'd1;
    else           busy_run <= '0;
  end

  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(cnt_gray ^ $past(cnt_gray)) == 1); // R2

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == 16'(SYNC_CYCLES)); // R5

  AST_BUSY_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmp_wr && (reg_addr == IDX_CMP_LO) |=> $stable(stage_lo)); // R6

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> flag_q); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !ctl_clear |=> flag_q); // R8

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_q && flag_q); // R9

  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit && ctl_clear |=> flag_q); // R10
endmodule

bind gray_event_timer gtmr_checker #(
  .CNT_W(CNT_W), .REG_W(REG_W), .SYNC_CYCLES(SYNC_CYCLES)
) u_gtmr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_o     (irq_o),
  .cnt_gray  (cnt_gray),
  .match_hit (match_hit),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .busy      (busy),
  .stage_lo  (stage_lo)
);

// File: tb/gray_event_timer_bench.sv
`timescale 1ns/1ps
module gray_event_timer_bench;
  localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_MLO = 3'd2, A_MHI = 3'd3, A_CTL = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gray_event_timer u_gray_event_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // {address, write data, expected readback}
  localparam logic [66:0] TBL [6] = '{
    {A_MLO, 32'h1234_5678, 32'h1234_5678},
    {A_MHI, 32'h0000_03A5, 32'h0000_03A5},
    {A_MHI, 32'hFFFF_FC01, 32'h0000_0001},
    {A_MLO, 32'h0000_0000, 32'h0000_0000},
    {A_MLO, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {A_MHI, 32'hFFFF_FFFF, 32'h0000_03FF}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // binary from Gray: walk down from the top bit
  function automatic logic [41:0] g2b(input logic [41:0] g);
    logic [41:0] b;
    b[41] = g[41];
    for (int i = 40; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [41:0] b2g(input logic [41:0] b);
    logic [41:0] g;
    for (int i = 0; i < 42; i++) g[i] = (i == 41) ? b[i] : (b[i] ^ b[i+1]);
    return g;
  endfunction

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // called in a falling-edge window; returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_count(output logic [41:0] b, output logic [31:0] raw_lo);
    logic [31:0] lo, hi;
    rd(A_CLO, lo);
    rd(A_CHI, hi);
    raw_lo = lo;
    b = g2b({hi[9:0], lo});
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 50; k++) begin
      rd(A_CTL, d);
      if (!d[2]) break;
      @(negedge clk);
    end
  endtask

  task automatic program_match(input logic [41:0] g);
    wr(A_MLO, g[31:0]);
    wr(A_MHI, {22'd0, g[41:32]});
    wait_idle();
  endtask

  task automatic wait_target(input logic [41:0] t, output bit found);
    logic [41:0] b;
    logic [31:0] raw;
    found = 1'b0;
    for (int k = 0; k < 400; k++) begin
      read_count(b, raw);
      if (b == t) begin found = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, raw, praw;
    logic [41:0] c, pc, t, g;
    bit found;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = A_CLO; reg_wdata = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    rd(A_CLO, d); chk("R1 count lo", d, 0);
    rd(A_CHI, d); chk("R1 count hi", d, 0);
    rd(A_MLO, d); chk("R1 match lo", d, 32'hFFFF_FFFF);
    rd(A_MHI, d); chk("R1 match hi", d, 32'h3FF);
    rd(A_CTL, d); chk("R1 ctrl", d, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: one step per clock, one bit change per step
    read_count(pc, praw);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      read_count(c, raw);
      chk("R2 increment", c, pc + 1);
      chk("R2 gray one-bit step", $countones(raw ^ praw), 1);
      pc = c; praw = raw;
    end
    // R3: high word layout
    rd(A_CHI, d); chk("R3 count hi bits", d, 0);

    // R4: table of compare writes and readbacks
    for (int i = 0; i < 6; i++) begin
      wr(TBL[i][66:64], TBL[i][63:32]);
      wait_idle();
      rd(TBL[i][66:64], d);
      chk("R4 compare readback", d, {32'd0, TBL[i][31:0]});
    end

    // R5: busy length
    wr(A_MHI, 32'h3FF);
    for (int i = 0; i < 3; i++) begin
      rd(A_CTL, d); chk("R5 busy high", d[2], 1);
      @(negedge clk);
    end
    rd(A_CTL, d); chk("R5 busy low after 3", d[2], 0);

    // R6: writes while busy dropped
    wr(A_MHI, 32'h3FF);
    wr(A_MLO, 32'hDEAD_BEEF);
    wr(A_MHI, 32'h155);
    rd(A_CTL, d); chk("R6 busy not extended", d[2], 1);
    @(negedge clk);
    rd(A_CTL, d); chk("R6 busy ends on time", d[2], 0);
    rd(A_MLO, d); chk("R6 lo write ignored", d, 32'hFFFF_FFFF);
    rd(A_MHI, d); chk("R6 hi write ignored", d, 32'h3FF);

    // R7 / R9: match with interrupt enabled
    wr(A_CTL, 32'h2);
    read_count(c, raw);
    t = c + 60;
    program_match(b2g(t));
    wait_target(t, found);
    chk("R7 target seen", found, 1);
    rd(A_CTL, d); chk("R7 flag not yet", d[0], 0);
    chk("R9 irq not yet", irq_o, 0);
    @(negedge clk);
    rd(A_CTL, d); chk("R7 flag one cycle later", d[0], 1);
    chk("R9 irq with enable", irq_o, 1);

    // R8 / R9: writing 0 keeps flag, enable off masks irq, write 1 clears
    wr(A_CTL, 32'h0);
    rd(A_CTL, d); chk("R8 write0 keeps flag", d[0], 1);
    chk("R9 irq masked", irq_o, 0);
    wr(A_CTL, 32'h1);
    rd(A_CTL, d); chk("R8 w1c clears", d[0], 0);

    // R8: flag set with enable off, then sticks
    read_count(c, raw);
    t = c + 40;
    program_match(b2g(t));
    wait_target(t, found);
    @(negedge clk);
    rd(A_CTL, d); chk("R8 flag set while disabled", d[0], 1);
    chk("R9 irq stays low when disabled", irq_o, 0);
    repeat (20) @(negedge clk);
    rd(A_CTL, d); chk("R8 flag sticky", d[0], 1);

    // R10: clear in the match cycle loses
    read_count(c, raw);
    t = c + 40;
    program_match(b2g(t));
    wait_target(t, found);
    chk("R10 target seen", found, 1);
    wr(A_CTL, 32'h1);
    rd(A_CTL, d); chk("R10 flag survives clear", d[0], 1);

    // R11: clear and enable in one write
    wr(A_CTL, 32'h3);
    rd(A_CTL, d); chk("R11 flag cleared", d[0], 0);
    chk("R11 enable set", d[1], 1);
    chk("R11 irq low", irq_o, 0);

    // R7: low half matches, high half differs -> no event
    read_count(c, raw);
    t = c + 30;
    g = b2g(t);
    g[35] = ~g[35];
    program_match(g);
    repeat (80) @(negedge clk);
    rd(A_CTL, d); chk("R7 high half compared", d[0], 0);
    chk("R9 irq idle", irq_o, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule